// File: doc/BRIEF.md
# Camera Command Demultiplexer

This block sits behind a link receiver that delivers 32-bit words, each with a one-cycle strobe. It sorts the configuration traffic for up to four cameras into one byte FIFO per camera. Each command stream opens with a word that names the target camera. The bytes that follow belong to that camera, and a carriage-return byte closes the stream. A typical command is a letter, an equals sign, a value, then the carriage return.

Each received word carries one byte in bits [9:2]. Bit 1 flags the byte as meaningful. Bit 0 and bits [31:10] must be zero. The block drives one write enable per camera FIFO and a registered data byte per lane. It takes a full indication back from each FIFO. A byte aimed at a full FIFO is lost, and a per-lane flag records the loss until reset. The FIFO storage and the serial drain towards the cameras live elsewhere.

Top module: `cam_cmd_demux`

## Requirements
- R1: While and directly after reset (rst_n low), every write enable is low, every overflow flag is clear, and the block waits for a camera-ID word.
- R2: While waiting, a strobed word with bit 1 set is taken as a camera-ID word, and its byte field [9:2] selects the camera. An ID word is never written to any FIFO.
- R3: While waiting, an ID word whose byte field is NUM_CAM (4) or more is ignored, and the block keeps waiting for the next ID word.
- R4: Once a camera is selected, each strobed word with bit 1 set raises only that camera's write enable, in the cycle after the strobe. The lane's data output carries byte field [9:2] of that word.
- R5: A word without the strobe, or a strobed word with bit 1 clear, neither writes nor changes the selection.
- R6: The carriage-return byte 0x0D is written to the selected FIFO. The block then waits for a new ID word, so the next valid byte is read as an ID and not as data.
- R7: A byte aimed at a FIFO whose full input is high in the strobe cycle is dropped, and that lane's overflow flag is set. The flag stays set until reset. A dropped 0x0D still ends the command stream.
- R8: A word with any of bits [31:10] set, or with bit 0 set, is ignored in both states.
- R9: At most one write enable is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 32 | Received link word |
| word_stb_i | input | 1 | One-cycle strobe qualifying word_i |
| fifo_full_i | input | 4 | Full indication of each camera FIFO |
| fifo_wr_o | output | 4 | Write enable of each camera FIFO |
| fifo_data_o | output | 32 | Write data, byte k for camera k |
| ovf_o | output | 4 | Sticky per-camera dropped-byte flag |

## Verification
The properties assume that the strobe, the word and the full inputs hold known values in every cycle after reset. They also assume that the full input of a lane, sampled at the strobe edge, decides whether the write happens. Neither the properties nor the bench expect the block to repair bad link framing. A word that breaks the format is simply ignored. The bench changes every input only on the falling clock edge. It sends camera IDs and command bytes from a fixed table and a few directed sequences, so every input is defined at each rising edge.

// File: rtl/cmd_demux_pkg.sv
package cmd_demux_pkg;
   typedef enum logic {
      ST_WAIT_ID  = 1'b0,
      ST_COLLECT  = 1'b1
   } route_st_t;
endpackage

// File: rtl/word_decoder.sv
module word_decoder #(
   parameter int WORD_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int BYTE_LSB = 2,
   parameter int FLAG_BIT = 1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              stb_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              accept_o
);
   localparam logic [WORD_W-1:0] BYTE_MASK =
      {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << BYTE_LSB;
   localparam logic [WORD_W-1:0] FLAG_MASK =
      {{(WORD_W-1){1'b0}}, 1'b1} << FLAG_BIT;
   localparam logic [WORD_W-1:0] USED_MASK = BYTE_MASK | FLAG_MASK;

   if (BYTE_LSB + BYTE_W > WORD_W) begin : g_bad_field
      $error("byte field does not fit in the word");
   end
   if (FLAG_BIT >= BYTE_LSB && FLAG_BIT < BYTE_LSB + BYTE_W) begin : g_bad_flag
      $error("flag bit overlaps the byte field");
   end

   logic reserved_set;

   always_comb begin
      byte_o       = word_i[BYTE_LSB +: BYTE_W];
      reserved_set = |(word_i & ~USED_MASK);
      accept_o     = stb_i & word_i[FLAG_BIT] & ~reserved_set;
   end
endmodule

// File: rtl/route_fsm.sv
module route_fsm
   import cmd_demux_pkg::*;
#(
   parameter int              NUM_CAM  = 4,
   parameter int              BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] EOC_CODE = 8'h0D,
   localparam int             IDW      = $clog2(NUM_CAM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              wr_req_o,
   output logic [IDW-1:0]    sel_o
);
   if (NUM_CAM < 2) begin : g_bad_cnt
      $error("at least two cameras are needed");
   end
   if (BYTE_W > 31) begin : g_bad_bw
      $error("byte width too large for the ID compare");
   end

   route_st_t st_q, st_d;
   logic [IDW-1:0] sel_q, sel_d;

   always_comb begin
      st_d     = st_q;
      sel_d    = sel_q;
      wr_req_o = 1'b0;
      case (st_q)
         ST_WAIT_ID: begin
            if (accept_i && (int'(byte_i) < NUM_CAM)) begin
               sel_d = byte_i[IDW-1:0];
               st_d  = ST_COLLECT;
            end
         end
         ST_COLLECT: begin
            if (accept_i) begin
               wr_req_o = 1'b1;
               if (byte_i == EOC_CODE) st_d = ST_WAIT_ID;
            end
         end
         default: st_d = ST_WAIT_ID;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_WAIT_ID;
         sel_q <= '0;
      end else begin
         st_q  <= st_d;
         sel_q <= sel_d;
      end
   end

   assign sel_o = sel_q;
endmodule

// File: rtl/lane_writer.sv
module lane_writer #(
   parameter int BYTE_W = 8,
   parameter int IDW    = 2,
   parameter int LANE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req_i,
   input  logic [IDW-1:0]    sel_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              full_i,
   output logic              wr_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              ovf_o
);
   logic hit;

   always_comb hit = wr_req_i && (sel_i == IDW'(LANE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_o   <= 1'b0;
         data_o <= '0;
         ovf_o  <= 1'b0;
      end else begin
         wr_o <= hit && !full_i;
         if (hit) data_o <= byte_i;
         if (hit && full_i) ovf_o <= 1'b1;
      end
   end
endmodule

// File: rtl/cam_cmd_demux.sv
module cam_cmd_demux #(
   parameter int              NUM_CAM  = 4,
   parameter int              WORD_W   = 32,
   parameter int              BYTE_W   = 8,
   parameter int              BYTE_LSB = 2,
   parameter int              FLAG_BIT = 1,
   parameter logic [BYTE_W-1:0] EOC_CODE = 8'h0D
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WORD_W-1:0]         word_i,
   input  logic                      word_stb_i,
   input  logic [NUM_CAM-1:0]        fifo_full_i,
   output logic [NUM_CAM-1:0]        fifo_wr_o,
   output logic [NUM_CAM*BYTE_W-1:0] fifo_data_o,
   output logic [NUM_CAM-1:0]        ovf_o
);
   localparam int IDW = $clog2(NUM_CAM);

   logic [BYTE_W-1:0] byte_w;
   logic              accept_w;
   logic              wr_req_w;
   logic [IDW-1:0]    sel_w;

   word_decoder #(
      .WORD_W(WORD_W), .BYTE_W(BYTE_W),
      .BYTE_LSB(BYTE_LSB), .FLAG_BIT(FLAG_BIT)
   ) u_dec (
      .word_i(word_i), .stb_i(word_stb_i),
      .byte_o(byte_w), .accept_o(accept_w)
   );

   route_fsm #(
      .NUM_CAM(NUM_CAM), .BYTE_W(BYTE_W), .EOC_CODE(EOC_CODE)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .byte_i(byte_w),
      .wr_req_o(wr_req_w), .sel_o(sel_w)
   );

   for (genvar k = 0; k < NUM_CAM; k++) begin : g_lane
      lane_writer #(
         .BYTE_W(BYTE_W), .IDW(IDW), .LANE(k)
      ) u_lane (
         .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req_w), .sel_i(sel_w),
         .byte_i(byte_w), .full_i(fifo_full_i[k]),
         .wr_o(fifo_wr_o[k]), .data_o(fifo_data_o[k*BYTE_W +: BYTE_W]),
         .ovf_o(ovf_o[k])
      );
   end
endmodule

// File: rtl/cmd_demux_chk.sv
module cmd_demux_chk #(
   parameter int NUM_CAM  = 4,
   parameter int WORD_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int BYTE_LSB = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [WORD_W-1:0]         word_i,
   input logic                      word_stb_i,
   input logic [NUM_CAM-1:0]        fifo_full_i,
   input logic [NUM_CAM-1:0]        fifo_wr_o,
   input logic [NUM_CAM*BYTE_W-1:0] fifo_data_o,
   input logic [NUM_CAM-1:0]        ovf_o
);
   // R9
   one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_wr_o));

   // R4
   wr_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fifo_wr_o) |-> $past(word_stb_i));

   for (genvar k = 0; k < NUM_CAM; k++) begin : g_lane_chk
      // R7
      full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fifo_wr_o[k] |-> !$past(fifo_full_i[k]));

      // R7
      ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_o[k] |=> ovf_o[k]);

      // R4
      data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fifo_wr_o[k] |->
            fifo_data_o[k*BYTE_W +: BYTE_W] == $past(word_i[BYTE_LSB +: BYTE_W]));
   end
endmodule

bind cam_cmd_demux cmd_demux_chk #(
   .NUM_CAM(NUM_CAM), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .BYTE_LSB(BYTE_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_stb_i(word_stb_i),
   .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o),
   .fifo_data_o(fifo_data_o), .ovf_o(ovf_o)
);

// File: tb/sim_cam_cmd_demux.sv
module sim_cam_cmd_demux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] word_i = '0;
   logic        word_stb_i = 1'b0;
   logic [3:0]  fifo_full_i = '0;
   logic [3:0]  fifo_wr_o;
   logic [31:0] fifo_data_o;
   logic [3:0]  ovf_o;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   cam_cmd_demux u0 (
      .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_stb_i(word_stb_i),
      .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o),
      .fifo_data_o(fifo_data_o), .ovf_o(ovf_o)
   );

   // {stb, byte, flag, full, exp_wr, exp_byte, exp_ovf}
   localparam int NV = 22;
   localparam logic [29:0] VEC [NV] = '{
      {1'b1, 8'h02, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h0}, // R2 select camera 2
      {1'b1, 8'h47, 1'b1, 4'h0, 4'b0100, 8'h47, 4'h0}, // R4
      {1'b1, 8'h3D, 1'b1, 4'h0, 4'b0100, 8'h3D, 4'h0}, // R4
      {1'b0, 8'h00, 1'b0, 4'h0, 4'b0000, 8'h00, 4'h0}, // R5 no strobe
      {1'b1, 8'h35, 1'b0, 4'h0, 4'b0000, 8'h00, 4'h0}, // R5 flag clear
      {1'b1, 8'h35, 1'b1, 4'h0, 4'b0100, 8'h35, 4'h0}, // R4
      {1'b1, 8'h0D, 1'b1, 4'h0, 4'b0100, 8'h0D, 4'h0}, // R6 CR written
      {1'b1, 8'h58, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h0}, // R6 read as ID
      {1'b1, 8'h47, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h0}, // R3
      {1'b1, 8'h07, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h0}, // R3
      {1'b1, 8'h41, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h0}, // R3 still waiting
      {1'b1, 8'h00, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h0}, // R2 camera 0
      {1'b1, 8'h41, 1'b1, 4'h1, 4'b0000, 8'h00, 4'h1}, // R7 drop
      {1'b1, 8'h3D, 1'b1, 4'h0, 4'b0001, 8'h3D, 4'h1}, // R7 sticky
      {1'b1, 8'h0D, 1'b1, 4'h1, 4'b0000, 8'h00, 4'h1}, // R7 CR dropped
      {1'b1, 8'h41, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h1}, // R7 stream ended
      {1'b1, 8'h03, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h1}, // R2 camera 3
      {1'b1, 8'h42, 1'b1, 4'h1, 4'b1000, 8'h42, 4'h1}, // R4 other lane full
      {1'b1, 8'h0D, 1'b1, 4'h0, 4'b1000, 8'h0D, 4'h1}, // R6
      {1'b1, 8'h01, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h1}, // R2 camera 1
      {1'b1, 8'h0D, 1'b1, 4'h0, 4'b0010, 8'h0D, 4'h1}, // R6 empty command
      {1'b1, 8'h41, 1'b1, 4'h0, 4'b0000, 8'h00, 4'h1}  // R6
   };

   task automatic check(input string req, input logic [3:0] ewr,
                        input logic [7:0] eb, input logic [3:0] eovf);
      n_vec++;
      if (fifo_wr_o !== ewr || ovf_o !== eovf) begin
         n_bad++;
         $display("FAIL %s wr=%b ovf=%b expected wr=%b ovf=%b",
                  req, fifo_wr_o, ovf_o, ewr, eovf);
      end
      for (int k = 0; k < 4; k++) begin
         if (ewr[k] && fifo_data_o[k*8 +: 8] !== eb) begin
            n_bad++;
            $display("FAIL %s lane %0d data=%h expected %h",
                     req, k, fifo_data_o[k*8 +: 8], eb);
         end
      end
   endtask

   task automatic send(input logic stb, input logic [31:0] w, input logic [3:0] full);
      word_stb_i  = stb;
      word_i      = w;
      fifo_full_i = full;
      @(negedge clk);
      word_stb_i  = 1'b0;
      word_i      = '0;
      fifo_full_i = '0;
   endtask

   function automatic logic [31:0] mkw(input logic [7:0] b, input logic f);
      return {22'b0, b, f, 1'b0};
   endfunction

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", 4'b0000, 8'h00, 4'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 4'b0000, 8'h00, 4'h0);

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][29], mkw(VEC[i][28:21], VEC[i][20]), VEC[i][19:16]);
         check($sformatf("table row %0d", i), VEC[i][15:12], VEC[i][11:4], VEC[i][3:0]);
      end

      // R8 reserved bits ignored while collecting
      send(1'b1, mkw(8'h01, 1'b1), 4'h0);
      check("R2 select 1", 4'b0000, 8'h00, 4'h1);
      send(1'b1, mkw(8'h41, 1'b1) | 32'h8000_0000, 4'h0);
      check("R8 bit31 set", 4'b0000, 8'h00, 4'h1);
      send(1'b1, mkw(8'h41, 1'b1) | 32'h0000_0001, 4'h0);
      check("R8 bit0 set", 4'b0000, 8'h00, 4'h1);
      send(1'b1, mkw(8'h41, 1'b1), 4'h0);
      check("R8 still collecting", 4'b0010, 8'h41, 4'h1);
      send(1'b1, mkw(8'h0D, 1'b1), 4'h0);
      check("R6 end", 4'b0010, 8'h0D, 4'h1);

      // R8 reserved bits ignored while waiting: bad ID word for camera 2
      send(1'b1, mkw(8'h02, 1'b1) | 32'h0000_0400, 4'h0);
      check("R8 bad ID word", 4'b0000, 8'h00, 4'h1);
      send(1'b1, mkw(8'h02, 1'b1), 4'h0);
      check("R8 next read as ID", 4'b0000, 8'h00, 4'h1);
      send(1'b1, mkw(8'h43, 1'b1), 4'h0);
      check("R4 camera 2 write", 4'b0100, 8'h43, 4'h1);

      // R1 reset mid-stream clears flag and selection
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears overflow", 4'b0000, 8'h00, 4'h0);
      rst_n = 1'b1;
      send(1'b1, mkw(8'h43, 1'b1), 4'h0);
      check("R1 waits for ID after reset", 4'b0000, 8'h00, 4'h0);

      report();
   end
endmodule